// File: doc/BRIEF.md
# Field Sequence Sync Generator

This block follows where the current field sits inside the colour field sequence of an analog television standard and drives one vertical-timing output pin whose meaning is chosen at run time. A field-start strobe from the line counter moves a 3-bit sequence counter forward. The sequence is four fields long for the 60 Hz standard and eight fields long for the 50 Hz standard. The counter value can be read at all times. Bit 0 of that value reports field parity: 0 is an odd field and 1 is an even field.

The output pin carries one of four functions:
- a vertical sync pulse of fixed length on every field;
- a frame-level signal that follows the odd/even indication sampled at each field start;
- a level that covers the one field per colour sequence in which the counter reads zero;
- a constant inactive level.

A polarity input chooses whether the active state is high or low. The mode and polarity inputs act on the pin in the same cycle. Everything else changes one clock after the field strobe.

Top module: `fsq_sync_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state: `seq_state` reads 0 (odd field), the sampled parity reads odd, and the vertical pulse is inactive.
- R2: With `std_50`=0 (60 Hz), each cycle in which `fld_strobe` is high advances `seq_state` by one at that edge, modulo 4. `seq_state[2]` stays 0 and `seq_state[0]`=1 marks an even field.
- R3: With `std_50`=1 (50 Hz), each strobe advances `seq_state` by one, modulo 8.
- R4: A change of `std_50` leaves `seq_state` untouched until the next strobe. At that strobe the new value is the old value plus one, modulo the length chosen by the new standard.
- R5: With `out_mode`=2'b00, the pin is active for exactly VS_LEN clock cycles, beginning in the cycle after a strobe. A strobe that arrives during a pulse restarts the full length.
- R6: With `out_mode`=2'b01, the pin is active when the `even_field` value sampled at the most recent strobe was 1. It is inactive after reset.
- R7: With `out_mode`=2'b10, the pin is active exactly while `seq_state` equals 0. This is one field per sequence: every fourth field at 60 Hz and every eighth field at 50 Hz.
- R8: With `out_mode`=2'b11, the pin holds the inactive level.
- R9: `sync_out` equals the active indication XOR `inv_pol`: active-high when `inv_pol`=0 and active-low when `inv_pol`=1. Changes of `out_mode` and `inv_pol` reach the pin without a register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fld_strobe | input | 1 | One-cycle pulse at the start of each field |
| even_field | input | 1 | Field parity from the line counter, 1 = even |
| std_50 | input | 1 | Standard select: 0 = 60 Hz (4-field sequence), 1 = 50 Hz (8-field sequence) |
| out_mode | input | 2 | Pin function: 0 vertical sync, 1 frame sync, 2 sequence pulse, 3 inactive |
| inv_pol | input | 1 | 1 makes the pin active-low |
| sync_out | output | 1 | Selected vertical-timing signal |
| seq_state | output | 3 | Field sequence counter, bit 0 = even field |

## Verification
The hardest situation to reach is a change of standard while the counter sits above 3. The eight-field count must be folded onto the four-field count at the next strobe, and it must not be folded earlier. The stimulus first runs six strobes in 50 Hz mode, then switches to 60 Hz and holds off the strobe for several cycles. It then checks that the value was kept and that the next strobe gives 3. A second hard case is a strobe that arrives while the vertical pulse is still running. Strobe gaps shorter than the pulse length reach it.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  localparam int SEQ_W = 3;

  typedef enum logic [1:0] {
    PIN_VSYNC = 2'd0,
    PIN_FRAME = 2'd1,
    PIN_SEQ   = 2'd2,
    PIN_NONE  = 2'd3
  } pin_mode_e;

  // Mask that folds the counter onto the sequence length of a standard.
  function automatic logic [SEQ_W-1:0] seq_mask(input logic std_50);
    return std_50 ? 3'd7 : 3'd3;
  endfunction

  // Next counter value after a field strobe.
  function automatic logic [SEQ_W-1:0] seq_next(input logic [SEQ_W-1:0] cur,
                                                input logic std_50);
    return (cur + 3'd1) & seq_mask(std_50);
  endfunction

  // Level on the pin for a given active indication and polarity.
  function automatic logic pin_level(input logic active, input logic inv);
    return active ^ inv;
  endfunction
endpackage

// File: rtl/fsq_field_tracker.sv
module fsq_field_tracker
  import fsq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             even_field,
  input  logic             std_50,
  output logic [SEQ_W-1:0] seq_q,
  output logic             par_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q <= '0;
      par_q <= 1'b0;
    end else if (step) begin
      seq_q <= seq_next(seq_q, std_50);
      par_q <= even_field;
    end
  end
endmodule

// File: rtl/fsq_vs_timer.sv
module fsq_vs_timer #(
  parameter int VS_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic active
);
  localparam int VS_W = $clog2(VS_LEN + 1);
  logic [VS_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst)                rem_q <= '0;
    else if (trig)          rem_q <= VS_W'(VS_LEN);
    else if (rem_q != '0)   rem_q <= rem_q - 1'b1;
  end

  assign active = (rem_q != '0);
endmodule

// File: rtl/fsq_pin_mux.sv
module fsq_pin_mux
  import fsq_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       inv,
  input  logic       vs_act,
  input  logic       frame_act,
  input  logic       seq_act,
  output logic       pin
);
  logic act;
  always_comb begin
    unique case (pin_mode_e'(mode))
      PIN_VSYNC: act = vs_act;
      PIN_FRAME: act = frame_act;
      PIN_SEQ:   act = seq_act;
      default:   act = 1'b0;
    endcase
    pin = pin_level(act, inv);
  end
endmodule

// File: rtl/fsq_sync_gen.sv
module fsq_sync_gen
  import fsq_pkg::*;
#(
  parameter int VS_LEN = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fld_strobe,
  input  logic       even_field,
  input  logic       std_50,
  input  logic [1:0] out_mode,
  input  logic       inv_pol,
  output logic       sync_out,
  output logic [2:0] seq_state
);
  // Named internal events, visible to the bound checker.
  logic             field_step;
  logic             vs_active;
  logic             frame_even;
  logic             seq_start;
  logic [SEQ_W-1:0] seq_q;

  assign field_step = fld_strobe & ~rst;

  fsq_field_tracker u_track (
    .clk(clk), .rst(rst), .step(field_step), .even_field(even_field),
    .std_50(std_50), .seq_q(seq_q), .par_q(frame_even)
  );

  fsq_vs_timer #(.VS_LEN(VS_LEN)) u_vs (
    .clk(clk), .rst(rst), .trig(field_step), .active(vs_active)
  );

  assign seq_start = (seq_q == '0);

  fsq_pin_mux u_mux (
    .mode(out_mode), .inv(inv_pol), .vs_act(vs_active),
    .frame_act(frame_even), .seq_act(seq_start), .pin(sync_out)
  );

  assign seq_state = seq_q;
endmodule

// File: rtl/fsq_sync_chk.sv
module fsq_sync_chk (
  input logic       clk,
  input logic       rst,
  input logic       fld_strobe,
  input logic       even_field,
  input logic       std_50,
  input logic [1:0] out_mode,
  input logic       inv_pol,
  input logic       sync_out,
  input logic [2:0] seq_state,
  input logic       vs_active,
  input logic       frame_even
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (seq_state == 3'd0 && !vs_active && !frame_even));

  a_r2_wrap4: assert property (@(posedge clk) disable iff (rst)
    (fld_strobe && !std_50) |=> seq_state == (($past(seq_state) + 3'd1) & 3'd3));

  a_r3_wrap8: assert property (@(posedge clk) disable iff (rst)
    (fld_strobe && std_50) |=> seq_state == ($past(seq_state) + 3'd1));

  a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
    !fld_strobe |=> $stable(seq_state));

  a_r5_retrigger: assert property (@(posedge clk) disable iff (rst)
    fld_strobe |=> vs_active);

  a_r6_parity_sample: assert property (@(posedge clk) disable iff (rst)
    fld_strobe |=> frame_even == $past(even_field));

  a_r7_seq_pin: assert property (@(posedge clk) disable iff (rst)
    (out_mode == 2'd2) |-> sync_out == ((seq_state == 3'd0) ^ inv_pol));

  a_r8_idle_pin: assert property (@(posedge clk) disable iff (rst)
    (out_mode == 2'd3) |-> sync_out == inv_pol);
endmodule

bind fsq_sync_gen fsq_sync_chk u_chk (
  .clk(clk), .rst(rst), .fld_strobe(fld_strobe), .even_field(even_field),
  .std_50(std_50), .out_mode(out_mode), .inv_pol(inv_pol),
  .sync_out(sync_out), .seq_state(seq_state),
  .vs_active(vs_active), .frame_even(frame_even)
);

// File: tb/fsq_sync_gen_tb.sv
`timescale 1ns/1ps
module fsq_sync_gen_tb;
  localparam int VS_LEN = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1, fld_strobe = 1'b0, even_field = 1'b0, std_50 = 1'b0;
  logic [1:0] out_mode = 2'd0;
  logic       inv_pol = 1'b0;
  logic       sync_out;
  logic [2:0] seq_state;

  int total = 0, bad = 0;
  int m_cnt = 0, m_par = 0, m_vs = 0;
  bit chk_on = 0, done = 0;

  fsq_sync_gen #(.VS_LEN(VS_LEN)) u_dut (
    .clk(clk), .rst(rst), .fld_strobe(fld_strobe), .even_field(even_field),
    .std_50(std_50), .out_mode(out_mode), .inv_pol(inv_pol),
    .sync_out(sync_out), .seq_state(seq_state)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: sequence position, sampled parity, pulse cycles left.
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_par = 0; m_vs = 0;
    end else if (fld_strobe) begin
      m_cnt = (m_cnt + 1) % (std_50 ? 8 : 4);
      m_par = even_field ? 1 : 0;
      m_vs  = VS_LEN;
    end else if (m_vs > 0) begin
      m_vs = m_vs - 1;
    end
  end

  // Compare every cycle away from the active edge.
  always @(negedge clk) begin
    if (chk_on && !rst) begin
      int act;
      string tag;
      check(seq_state == 3'(m_cnt), std_50 ? "R3 state" : "R2 state", seq_state, m_cnt);
      case (out_mode)
        2'd0: begin act = (m_vs > 0);  tag = "R5,R9 vsync"; end
        2'd1: begin act = m_par;       tag = "R6,R9 frame"; end
        2'd2: begin act = (m_cnt == 0); tag = "R7,R9 seq"; end
        default: begin act = 0;        tag = "R8,R9 idle"; end
      endcase
      check(sync_out == (act[0] ^ inv_pol), tag, sync_out, act ^ inv_pol);
    end
  end

  task automatic field(input int gap, input bit ev);
    @(posedge clk); #1 fld_strobe = 1'b1; even_field = ev;
    @(posedge clk); #1 fld_strobe = 1'b0;
    repeat (gap) @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(input logic [1:0] m, input bit p, input bit s);
    @(posedge clk); #1 out_mode = m; inv_pol = p; std_50 = s;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    out_mode = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(seq_state == 3'd0, "R1 reset state", seq_state, 0);
    check(sync_out == 1'b1, "R1 seq pin active at count 0", sync_out, 1);
    #1 out_mode = 2'd0;
    #0.1 check(sync_out == 1'b0, "R1 no vsync in reset", sync_out, 0);
    @(posedge clk); #1 rst = 1'b0; chk_on = 1;

    // Vertical sync, long and short (retrigger) field gaps
    set_cfg(2'd0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) field(10, i[0]);
    for (int i = 0; i < 5; i++) field(2 + i % 3, i[0]);
    field(12, 1'b0);
    set_cfg(2'd0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) field(9, 1'b1);

    // Frame sync following sampled parity
    set_cfg(2'd1, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) field(4, i[0]);
    field(4, 1'b1); field(4, 1'b1); field(4, 1'b0);
    set_cfg(2'd1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) field(3, ~i[0]);

    // Sequence pulse, 60 Hz then 50 Hz from a known start
    @(posedge clk); #1 rst = 1'b1; @(posedge clk); #1 rst = 1'b0;
    set_cfg(2'd2, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) field(3, 1'b0);
    @(negedge clk);
    check(seq_state == 3'd0, "R2 wrap after four fields", seq_state, 0);
    for (int i = 0; i < 5; i++) field(3, 1'b0);
    set_cfg(2'd2, 1'b1, 1'b1);
    @(posedge clk); #1 rst = 1'b1; @(posedge clk); #1 rst = 1'b0;
    for (int i = 0; i < 7; i++) field(3, 1'b0);
    @(negedge clk);
    check(seq_state == 3'd7, "R3 reaches seven", seq_state, 7);
    field(3, 1'b0);
    @(negedge clk);
    check(seq_state == 3'd0, "R3 wrap after eight fields", seq_state, 0);
    for (int i = 0; i < 9; i++) field(2, 1'b0);

    // Standard change folds only at the next strobe
    @(posedge clk); #1 rst = 1'b1; @(posedge clk); #1 rst = 1'b0;
    set_cfg(2'd2, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) field(2, 1'b0);
    set_cfg(2'd2, 1'b0, 1'b0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(seq_state == 3'd6, "R4 held until strobe", seq_state, 6);
    field(2, 1'b0);
    @(negedge clk);
    check(seq_state == 3'd3, "R4 folded to four-field length", seq_state, 3);
    for (int i = 0; i < 5; i++) field(2, 1'b0);

    // Inactive mode with both polarities
    set_cfg(2'd3, 1'b0, 1'b0);
    field(3, 1'b1);
    @(negedge clk);
    check(sync_out == 1'b0, "R8 idle active-high", sync_out, 0);
    set_cfg(2'd3, 1'b1, 1'b1);
    field(3, 1'b0);
    @(negedge clk);
    check(sync_out == 1'b1, "R9 idle active-low", sync_out, 1);

    repeat (4) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule